// File: doc/BRIEF.md
# Receive Ring Buffer Pointer Manager

This block keeps the address bookkeeping for the receive part of a packet buffer memory that it shares with a transmit area. The transmit area takes the lowest `tx_size_i` words. Every word from that boundary up to the top of the address space forms a circular receive ring. The receiver reports packet start, data words, packet end and packet rejection. The block returns the memory address for each data word. At packet end it also returns the address and word count of a one-word header slot, which it reserved at packet start. Packets sit back to back in the ring, with no gaps between them.

The host side takes packets out of the ring. It first reads a header word, which tells it the length. It then reads the data words. Both the write and read positions wrap from the last memory address back to the ring base. Each position carries a lap bit, so a completely full ring and an empty ring can be told apart. When the ring is empty and no packet is being received, both positions return to the ring base. This lets a new transmit size take effect at that point.

A packet that does not fit is dropped. Its partial words are discarded by moving the write position back to the packet's start, and a sticky overflow flag is set. The configured transmit size may only change while the ring is empty and no packet is being received.

Top module: `rxring_mgr`

## Requirements
- R1: While the ring is empty and no packet is in progress, `rd_addr_o` and `mem_waddr_o` equal `tx_size_i` one clock after it is applied.
- R2: A start strobe reserves one header word at the current write position. The data words of the packet go to the addresses that follow it, one per accepted write strobe. Each accepted write has `mem_we_o` high in the same cycle, with the address on `mem_waddr_o`.
- R3: An end strobe on a packet that has not been dropped raises `hdr_we_o` in the same cycle. In that cycle `hdr_addr_o` is the reserved header address and `hdr_len_o` is the number of data words. The next packet's header goes to the word right after the last data word.
- R4: After address 2^AW-1, the next address for both the write and the read position is `tx_size_i`.
- R5: `pkt_avail_o` is high while at least one finished packet's header has not been read. Each `host_hdr_rd_i` moves the read position by one word and removes one packet from that count.
- R6: `fill_o` is the number of committed words (headers plus data) between the read position and the end of the last finished packet. `empty_o` is high exactly when `fill_o` is 0. A full ring shows the ring size, 2^AW - `tx_size_i`.
- R7: A write strobe when the write position is a full lap ahead of the read position does not write (`mem_we_o` low). It sets the overflow flag and drops the packet. The write position rolls back to the packet's header address. Later writes and the end strobe of that packet produce no write and no header.
- R8: A start strobe when the committed ring is full sets the overflow flag, and that packet is dropped the same way.
- R9: An abort strobe discards the packet in progress. The next packet's header reuses the same address, and the packet count does not change.
- R10: `host_rd_i` is ignored while the ring is empty. `host_hdr_rd_i` is ignored while no finished packet is waiting.
- R11: The overflow flag stays set until `ovf_clr_i` is pulsed, and it then reads 0.
- R12: The receiver gives at most one of start, write, end and abort per cycle. A start while a packet is in progress restarts that packet at the same header address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_size_i | input | AW | Words given to the transmit area; also the ring base address |
| rx_sop_i | input | 1 | Receiver packet start |
| rx_wr_i | input | 1 | Receiver data word strobe |
| rx_eop_i | input | 1 | Receiver packet end, packet good |
| rx_abort_i | input | 1 | Receiver rejects the packet in progress |
| host_rd_i | input | 1 | Host consumed one data word |
| host_hdr_rd_i | input | 1 | Host consumed one header word |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| mem_we_o | output | 1 | Data word write enable |
| mem_waddr_o | output | AW | Data word write address |
| hdr_we_o | output | 1 | Header write enable |
| hdr_addr_o | output | AW | Header write address |
| hdr_len_o | output | AW+1 | Header content: data word count |
| rd_addr_o | output | AW | Address the host reads next |
| pkt_avail_o | output | 1 | At least one finished packet is waiting |
| empty_o | output | 1 | No committed words in the ring |
| fill_o | output | AW+1 | Committed words in the ring |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A write position that is off by one, or that ignores the lap, shows up in the same cycle. The wrong value appears on `mem_waddr_o` at the next data word, or as a `mem_we_o` that stays low or goes high when it should not. A missed rollback shows at the next packet's first header address. A bad read position or packet count is seen on `rd_addr_o`, `fill_o` and `pkt_avail_o` one clock after the host strobe that caused it. The directed scenarios drive packets across the top of memory, fill the ring to exactly its size, and then push one word past that point, so lap-bit errors show up within a packet length.

// File: rtl/rxring_adv.sv
module rxring_adv #(
    parameter int AW = 8
) (
    input  logic [AW:0]   ptr_i,
    input  logic [AW-1:0] base_i,
    output logic [AW:0]   nxt_o
);
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    // Step one word; past the top address, fold to the ring base and flip the lap bit.
    always_comb begin
        if (ptr_i[AW-1:0] == TOP) begin
            nxt_o = {~ptr_i[AW], base_i};
        end else begin
            nxt_o = {ptr_i[AW], ptr_i[AW-1:0] + 1'b1};
        end
    end
endmodule

// File: rtl/rxring_level.sv
module rxring_level #(
    parameter int AW = 8
) (
    input  logic [AW:0]   rd_i,
    input  logic [AW:0]   wr_i,
    input  logic [AW-1:0] base_i,
    output logic [AW:0]   fill_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam logic [AW:0] SPACE = {1'b1, {AW{1'b0}}};

    logic [AW:0] ring_n;
    logic [AW:0] wa;
    logic [AW:0] ra;

    always_comb begin
        ring_n  = SPACE - {1'b0, base_i};
        wa      = {1'b0, wr_i[AW-1:0]};
        ra      = {1'b0, rd_i[AW-1:0]};
        fill_o  = (rd_i[AW] == wr_i[AW]) ? (wa - ra) : (ring_n + wa - ra);
        empty_o = (rd_i == wr_i);
        full_o  = (rd_i[AW-1:0] == wr_i[AW-1:0]) && (rd_i[AW] != wr_i[AW]);
    end
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] tx_size_i,
    input  logic          rx_sop_i,
    input  logic          rx_wr_i,
    input  logic          rx_eop_i,
    input  logic          rx_abort_i,
    input  logic          host_rd_i,
    input  logic          host_hdr_rd_i,
    input  logic          ovf_clr_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic          hdr_we_o,
    output logic [AW-1:0] hdr_addr_o,
    output logic [AW:0]   hdr_len_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          pkt_avail_o,
    output logic          empty_o,
    output logic [AW:0]   fill_o,
    output logic          ovf_o
);
    localparam int PW = AW + 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] cwp;
        logic [PW-1:0] wp;
        logic [PW-1:0] st;
        logic          busy;
        logic          drop;
        logic          ovf;
        logic [CW-1:0] cnt;
        logic [AW:0]   len;
    } state_t;

    state_t s_q, s_d;

    logic [PW-1:0] base_p;
    logic [PW-1:0] wp_nx, cwp_nx, rp_nx;
    logic [AW:0]   cfill, wfill;
    logic          cempty, cfull, wempty, wfull;
    logic          we_c, hwe_c;

    assign base_p = {1'b0, tx_size_i};

    rxring_adv #(.AW(AW)) u_adv_wp  (.ptr_i(s_q.wp),  .base_i(tx_size_i), .nxt_o(wp_nx));
    rxring_adv #(.AW(AW)) u_adv_cwp (.ptr_i(s_q.cwp), .base_i(tx_size_i), .nxt_o(cwp_nx));
    rxring_adv #(.AW(AW)) u_adv_rp  (.ptr_i(s_q.rp),  .base_i(tx_size_i), .nxt_o(rp_nx));

    rxring_level #(.AW(AW)) u_lvl_commit (
        .rd_i(s_q.rp), .wr_i(s_q.cwp), .base_i(tx_size_i),
        .fill_o(cfill), .empty_o(cempty), .full_o(cfull)
    );
    rxring_level #(.AW(AW)) u_lvl_work (
        .rd_i(s_q.rp), .wr_i(s_q.wp), .base_i(tx_size_i),
        .fill_o(wfill), .empty_o(wempty), .full_o(wfull)
    );

    always_comb begin
        s_d   = s_q;
        we_c  = 1'b0;
        hwe_c = 1'b0;

        // host side: header read wins over data read
        if (host_hdr_rd_i && (s_q.cnt != '0)) begin
            s_d.rp  = rp_nx;
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (host_rd_i && !cempty) begin
            s_d.rp = rp_nx;
        end

        if (ovf_clr_i) begin
            s_d.ovf = 1'b0;
        end

        // receive side: one event per cycle
        if (rx_abort_i) begin
            if (s_q.busy) begin
                s_d.busy = 1'b0;
                s_d.drop = 1'b0;
                s_d.wp   = s_q.st;
            end
        end else if (rx_eop_i) begin
            if (s_q.busy) begin
                s_d.busy = 1'b0;
                s_d.drop = 1'b0;
                if (!s_q.drop) begin
                    hwe_c   = 1'b1;
                    s_d.cwp = s_q.wp;
                    s_d.cnt = s_d.cnt + 1'b1;
                end
            end
        end else if (rx_wr_i) begin
            if (s_q.busy && !s_q.drop) begin
                if (wfull) begin
                    s_d.ovf  = 1'b1;
                    s_d.drop = 1'b1;
                    s_d.wp   = s_q.st;
                end else begin
                    we_c    = 1'b1;
                    s_d.wp  = wp_nx;
                    s_d.len = s_q.len + 1'b1;
                end
            end
        end else if (rx_sop_i) begin
            s_d.st   = s_q.cwp;
            s_d.len  = '0;
            s_d.drop = 1'b0;
            if (cfull) begin
                s_d.ovf  = 1'b1;
                s_d.busy = 1'b0;
                s_d.wp   = s_q.cwp;
            end else begin
                s_d.busy = 1'b1;
                s_d.wp   = cwp_nx;
            end
        end

        // idle and empty: park every position at the ring base
        if (!s_d.busy && (s_d.cwp == s_d.rp)) begin
            s_d.rp  = base_p;
            s_d.cwp = base_p;
            s_d.wp  = base_p;
            s_d.st  = base_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we_o    = we_c;
    assign mem_waddr_o = s_q.wp[AW-1:0];
    assign hdr_we_o    = hwe_c;
    assign hdr_addr_o  = s_q.st[AW-1:0];
    assign hdr_len_o   = s_q.len;
    assign rd_addr_o   = s_q.rp[AW-1:0];
    assign pkt_avail_o = (s_q.cnt != '0);
    assign empty_o     = cempty;
    assign fill_o      = cfill;
    assign ovf_o       = s_q.ovf;

    // R12
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rx_sop_i, rx_wr_i, rx_eop_i, rx_abort_i}) <= 1);

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= ({1'b1, {AW{1'b0}}} - {1'b0, tx_size_i}));

    // R5
    empty_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !pkt_avail_o);

    // R3
    hdr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we_o && !(host_hdr_rd_i && pkt_avail_o) |=> s_q.cnt == $past(s_q.cnt) + 1'b1);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i |=> ovf_o);

    // R9
    abort_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort_i && s_q.busy |=> !s_q.busy && !hdr_we_o);

    // R2
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_waddr_o >= tx_size_i);
endmodule

// File: tb/test_rxring_mgr.sv
module test_rxring_mgr;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] tx_size = 5'd20;
    logic          sop = 0, wr = 0, eop = 0, ab = 0, hrd = 0, hhd = 0, clr = 0;
    logic          mem_we, hdr_we, pkt_avail, empty, ovf;
    logic [AW-1:0] waddr, hdr_addr, rd_addr;
    logic [AW:0]   hdr_len, fill;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic          l_we, l_hwe;
    logic [AW-1:0] l_waddr, l_haddr;
    logic [AW:0]   l_hlen;

    always #10 clk = ~clk;

    rxring_mgr #(.AW(AW)) i_rxring_mgr (
        .clk(clk), .rst_n(rst_n), .tx_size_i(tx_size),
        .rx_sop_i(sop), .rx_wr_i(wr), .rx_eop_i(eop), .rx_abort_i(ab),
        .host_rd_i(hrd), .host_hdr_rd_i(hhd), .ovf_clr_i(clr),
        .mem_we_o(mem_we), .mem_waddr_o(waddr), .hdr_we_o(hdr_we),
        .hdr_addr_o(hdr_addr), .hdr_len_o(hdr_len), .rd_addr_o(rd_addr),
        .pkt_avail_o(pkt_avail), .empty_o(empty), .fill_o(fill), .ovf_o(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of stimulus; same-cycle outputs captured before the edge
    task automatic step(input logic s, input logic w, input logic e, input logic a,
                        input logic r, input logic h, input logic c);
        @(negedge clk);
        sop = s; wr = w; eop = e; ab = a; hrd = r; hhd = h; clr = c;
        #1;
        l_we = mem_we; l_waddr = waddr; l_hwe = hdr_we; l_haddr = hdr_addr; l_hlen = hdr_len;
        @(posedge clk);
        #1;
        sop = 0; wr = 0; eop = 0; ab = 0; hrd = 0; hhd = 0; clr = 0;
    endtask

    task automatic t_reset;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 rd_addr at base", rd_addr, 20);
        chk("R1 waddr at base", waddr, 20);
        chk("R6 empty after reset", empty, 1);
        chk("R6 fill after reset", fill, 0);
        chk("R5 no packet after reset", pkt_avail, 0);
        chk("R11 ovf after reset", ovf, 0);
    endtask

    task automatic t_basic;
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 3; i++) begin
            step(0,1,0,0,0,0,0);
            chk("R2 data we", l_we, 1);
            chk("R2 data addr", l_waddr, 21 + i);
        end
        step(0,0,1,0,0,0,0);
        chk("R3 hdr we", l_hwe, 1);
        chk("R3 hdr addr", l_haddr, 20);
        chk("R3 hdr len", l_hlen, 3);
        chk("R6 fill after packet", fill, 4);
        chk("R5 avail after packet", pkt_avail, 1);
        step(0,0,0,0,0,1,0);
        chk("R5 avail after hdr read", pkt_avail, 0);
        chk("R5 rd after hdr read", rd_addr, 21);
        chk("R6 fill after hdr read", fill, 3);
        for (int i = 0; i < 3; i++) step(0,0,0,0,1,0,0);
        chk("R6 empty after drain", empty, 1);
        chk("R1 rd parked at base", rd_addr, 20);
    endtask

    task automatic t_wrap;
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 5; i++) step(0,1,0,0,0,0,0);
        step(0,0,1,0,0,0,0);
        step(0,0,0,0,0,1,0);
        for (int i = 0; i < 4; i++) step(0,0,0,0,1,0,0);
        chk("R6 fill one left", fill, 1);
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 8; i++) begin
            step(0,1,0,0,0,0,0);
            chk("R4 write addr across top", l_waddr, (i < 5) ? 27 + i : 15 + i);
        end
        step(0,0,1,0,0,0,0);
        chk("R3 hdr addr second", l_haddr, 26);
        chk("R3 hdr len second", l_hlen, 8);
        chk("R6 fill across top", fill, 10);
        step(0,0,0,0,1,0,0);
        step(0,0,0,0,0,1,0);
        chk("R5 count down", pkt_avail, 0);
        for (int i = 0; i < 5; i++) step(0,0,0,0,1,0,0);
        chk("R4 read addr wraps", rd_addr, 20);
        chk("R6 fill after read wrap", fill, 3);
        for (int i = 0; i < 3; i++) step(0,0,0,0,1,0,0);
        chk("R6 empty after wrap drain", empty, 1);
    endtask

    task automatic t_overflow;
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 11; i++) step(0,1,0,0,0,0,0);
        chk("R2 last fitting word", l_we, 1);
        step(0,1,0,0,0,0,0);
        chk("R7 no write when full", l_we, 0);
        chk("R7 ovf set", ovf, 1);
        chk("R7 rolled back", waddr, 20);
        step(0,1,0,0,0,0,0);
        chk("R7 later write ignored", l_we, 0);
        step(0,0,1,0,0,0,0);
        chk("R7 no header for dropped", l_hwe, 0);
        chk("R7 no packet counted", pkt_avail, 0);
        chk("R7 ring still empty", empty, 1);
        step(0,0,0,0,0,0,0);
        chk("R11 ovf holds", ovf, 1);
        step(0,0,0,0,0,0,1);
        chk("R11 ovf cleared", ovf, 0);
    endtask

    task automatic t_full_sop;
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 11; i++) step(0,1,0,0,0,0,0);
        step(0,0,1,0,0,0,0);
        chk("R3 full packet len", l_hlen, 11);
        chk("R6 full ring fill", fill, 12);
        chk("R6 full ring not empty", empty, 0);
        step(1,0,0,0,0,0,0);
        chk("R8 ovf on start", ovf, 1);
        step(0,1,0,0,0,0,0);
        chk("R8 dropped write", l_we, 0);
        step(0,0,1,0,0,0,0);
        chk("R8 dropped header", l_hwe, 0);
        chk("R8 fill kept", fill, 12);
        step(0,0,0,0,0,1,0);
        for (int i = 0; i < 11; i++) step(0,0,0,0,1,0,0);
        chk("R6 full drain empty", empty, 1);
        step(0,0,0,0,0,0,1);
    endtask

    task automatic t_abort_restart;
        step(1,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0);
        step(0,1,0,0,0,0,0);
        step(0,0,0,1,0,0,0);
        chk("R9 no packet after abort", pkt_avail, 0);
        chk("R9 waddr back", waddr, 20);
        step(1,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0);
        chk("R9 first addr reused", l_waddr, 21);
        step(1,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0);
        chk("R12 restart addr", l_waddr, 21);
        step(0,0,1,0,0,0,0);
        chk("R12 hdr addr", l_haddr, 20);
        chk("R12 hdr len", l_hlen, 1);
        chk("R6 fill restart", fill, 2);
        step(0,0,0,0,0,1,0);
        step(0,0,0,0,1,0,0);
        chk("R6 empty again", empty, 1);
    endtask

    task automatic t_ignored_and_base;
        step(0,0,0,0,1,0,0);
        chk("R10 rd ignored when empty", rd_addr, 20);
        chk("R10 fill unchanged", fill, 0);
        step(0,0,0,0,0,1,0);
        chk("R10 hdr read ignored", rd_addr, 20);
        chk("R10 avail unchanged", pkt_avail, 0);
        @(negedge clk);
        tx_size = 5'd24;
        @(posedge clk);
        #1;
        chk("R1 rd follows new base", rd_addr, 24);
        chk("R1 waddr follows new base", waddr, 24);
        step(1,0,0,0,0,0,0);
        step(0,1,0,0,0,0,0);
        chk("R2 data after new base", l_waddr, 25);
        step(0,0,1,0,0,0,0);
        chk("R3 hdr at new base", l_haddr, 24);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wrap();
        t_overflow();
        t_full_sop();
        t_abort_restart();
        t_ignored_and_base();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule